// File: doc/BRIEF.md
# Switched-Bank Cluster Register File

This block is the register storage for one datapath cluster with two execution units: a load/store unit and an arithmetic unit. Each unit has a private file of eight 32-bit registers. The two units also share a file of sixteen registers, which is split into two banks of eight. A single switch bit, supplied with each instruction bundle, hands one shared bank to each unit for that cycle. The two units therefore never touch the same bank together, and each bank needs only one set of ports. These ports are steered between the units rather than duplicated.

Each unit has two read ports and one write port, and each port carries a 5-bit register address. The block decodes every address against the bank that the unit owns in that cycle. It drops writes that land outside the unit's reach and returns zero for reads that do. For any such access it raises that unit's illegal-access flag. Reads are combinational and write-first: a read of a register that the same unit writes in the same cycle returns the incoming data. Writes are committed at the rising clock edge.

Top module: `pingpong_cluster_rf`

## Requirements
- R1: A synchronous active-high reset clears all 32 registers (both private files and both shared banks) to zero.
- R2: Addresses 0 to 7 select the issuing unit's own private file: address n is A-register n for the load/store unit and AC-register n for the arithmetic unit. A write by one unit never changes the other unit's private register.
- R3: The switch bit sets bank ownership. With the bit at 0, the load/store unit owns bank 0 (addresses 8 to 15 name D0 to D7) and the arithmetic unit owns bank 1 (addresses 16 to 23 name D8 to D15). With the bit at 1, the ownership is reversed. Shared contents persist across switches.
- R4: A read that names a shared register in the bank the unit does not own returns zero and raises that unit's illegal flag in the same cycle.
- R5: A write that names a shared register in the unowned bank raises the unit's illegal flag, and the register keeps its old value.
- R6: Addresses 24 to 31 are illegal on any port. A read at such an address returns zero, a write is discarded, and the unit's flag is raised.
- R7: A write presented in a cycle becomes visible to reads from the following cycle onward.
- R8: A read of a register that the same unit writes in the same cycle returns the write data (write-first bypass).
- R9: When both units name the same shared register in the same cycle, exactly one of them gets the access and the other is flagged.
- R10: Each flag covers only its own unit's ports (both read ports, plus the write port when its enable is high). One unit's illegal access leaves the other unit's flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bank_swap | input | 1 | Per-bundle bank switch: 0 gives the load/store unit bank 0, 1 gives it bank 1 |
| ls_ra0 | input | 5 | Load/store read address, port 0 |
| ls_ra1 | input | 5 | Load/store read address, port 1 |
| ls_we | input | 1 | Load/store write enable |
| ls_wa | input | 5 | Load/store write address |
| ls_wd | input | 32 | Load/store write data |
| ls_rd0 | output | 32 | Load/store read data, port 0 |
| ls_rd1 | output | 32 | Load/store read data, port 1 |
| ls_illegal | output | 1 | Load/store illegal-access flag |
| ar_ra0 | input | 5 | Arithmetic read address, port 0 |
| ar_ra1 | input | 5 | Arithmetic read address, port 1 |
| ar_we | input | 1 | Arithmetic write enable |
| ar_wa | input | 5 | Arithmetic write address |
| ar_wd | input | 32 | Arithmetic write data |
| ar_rd0 | output | 32 | Arithmetic read data, port 0 |
| ar_rd1 | output | 32 | Arithmetic read data, port 1 |
| ar_illegal | output | 1 | Arithmetic illegal-access flag |

## Verification
The hardest case to reach is a shared register that one unit writes under one switch setting and the other unit later reads after the bit has flipped. This is the only path by which data crosses between the units, and a mis-steered bank port shows up only there. The stimulus sequences the switch bit across consecutive bundles: it writes distinct values into both banks, flips the bit and reads each value back through the other unit. It then tries a write into the unowned bank and flips back, so that the owning unit can show the old value is still in place.

// File: rtl/pp_rf_pkg.sv
package pp_rf_pkg;
  typedef enum logic [1:0] {
    RK_PRIV = 2'd0,
    RK_SHR  = 2'd1,
    RK_BAD  = 2'd2
  } rkind_t;

  localparam int NUM_UNITS = 2;
  localparam int NUM_PORTS = 3;   // read 0, read 1, write
  localparam int UNIT_LS   = 0;
  localparam int UNIT_AR   = 1;
endpackage

// File: rtl/rf_addr_dec.sv
module rf_addr_dec
  import pp_rf_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int PRIV_DEPTH = 8,
  parameter int BANK_DEPTH = 8,
  parameter int IDX_W      = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output rkind_t            kind,
  output logic              bank,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W:0] LIM_PRIV = (ADDR_W+1)'(PRIV_DEPTH);
  localparam logic [ADDR_W:0] LIM_B0   = (ADDR_W+1)'(PRIV_DEPTH + BANK_DEPTH);
  localparam logic [ADDR_W:0] LIM_B1   = (ADDR_W+1)'(PRIV_DEPTH + 2*BANK_DEPTH);

  logic [ADDR_W:0] ax;
  assign ax = {1'b0, addr};

  always_comb begin
    kind = RK_BAD;
    bank = 1'b0;
    idx  = '0;
    if (ax < LIM_PRIV) begin
      kind = RK_PRIV;
      idx  = IDX_W'(ax);
    end else if (ax < LIM_B0) begin
      kind = RK_SHR;
      idx  = IDX_W'(ax - LIM_PRIV);
    end else if (ax < LIM_B1) begin
      kind = RK_SHR;
      bank = 1'b1;
      idx  = IDX_W'(ax - LIM_B0);
    end
  end
endmodule

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [IDX_W-1:0]  ra0,
  input  logic [IDX_W-1:0]  ra1,
  output logic [DATA_W-1:0] rd0,
  output logic [DATA_W-1:0] rd1
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wa] <= wd;
    end
  end

  // write-first bypass on both read ports
  assign rd0 = (we && wa == ra0) ? wd : mem[ra0];
  assign rd1 = (we && wa == ra1) ? wd : mem[ra1];

  // R7
  write_commit_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(wa)] == $past(wd));

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !we) |-> (rd0 == '0 && rd1 == '0));
endmodule

// File: rtl/pingpong_cluster_rf.sv
module pingpong_cluster_rf
  import pp_rf_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int PRIV_DEPTH = 8,
  parameter int BANK_DEPTH = 8,
  parameter int ADDR_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bank_swap,
  input  logic [ADDR_W-1:0] ls_ra0,
  input  logic [ADDR_W-1:0] ls_ra1,
  input  logic              ls_we,
  input  logic [ADDR_W-1:0] ls_wa,
  input  logic [DATA_W-1:0] ls_wd,
  output logic [DATA_W-1:0] ls_rd0,
  output logic [DATA_W-1:0] ls_rd1,
  output logic              ls_illegal,
  input  logic [ADDR_W-1:0] ar_ra0,
  input  logic [ADDR_W-1:0] ar_ra1,
  input  logic              ar_we,
  input  logic [ADDR_W-1:0] ar_wa,
  input  logic [DATA_W-1:0] ar_wd,
  output logic [DATA_W-1:0] ar_rd0,
  output logic [DATA_W-1:0] ar_rd1,
  output logic              ar_illegal
);
  localparam int MAX_DEPTH = (PRIV_DEPTH > BANK_DEPTH) ? PRIV_DEPTH : BANK_DEPTH;
  localparam int IDX_W     = (MAX_DEPTH > 1) ? $clog2(MAX_DEPTH) : 1;
  localparam int PIDX_W    = (PRIV_DEPTH > 1) ? $clog2(PRIV_DEPTH) : 1;
  localparam int BIDX_W    = (BANK_DEPTH > 1) ? $clog2(BANK_DEPTH) : 1;
  localparam logic [ADDR_W-1:0] A_B0 = ADDR_W'(PRIV_DEPTH);
  localparam logic [ADDR_W-1:0] A_B1 = ADDR_W'(PRIV_DEPTH + BANK_DEPTH);
  localparam logic [ADDR_W-1:0] A_END = ADDR_W'(PRIV_DEPTH + 2*BANK_DEPTH);

  // per-unit, per-port address bundle: ports 0,1 read, port 2 write
  logic [ADDR_W-1:0] addr  [NUM_UNITS][NUM_PORTS];
  logic              u_we  [NUM_UNITS];
  logic [DATA_W-1:0] u_wd  [NUM_UNITS];
  rkind_t            kind  [NUM_UNITS][NUM_PORTS];
  logic              bsel  [NUM_UNITS][NUM_PORTS];
  logic [IDX_W-1:0]  idx   [NUM_UNITS][NUM_PORTS];
  logic              own   [NUM_UNITS];
  logic              legal [NUM_UNITS][NUM_PORTS];
  logic              illeg [NUM_UNITS];
  logic [DATA_W-1:0] prv_rd [NUM_UNITS][2];
  logic [DATA_W-1:0] bnk_rd [2][2];
  logic [DATA_W-1:0] rd     [NUM_UNITS][2];

  assign addr[UNIT_LS][0] = ls_ra0;
  assign addr[UNIT_LS][1] = ls_ra1;
  assign addr[UNIT_LS][2] = ls_wa;
  assign addr[UNIT_AR][0] = ar_ra0;
  assign addr[UNIT_AR][1] = ar_ra1;
  assign addr[UNIT_AR][2] = ar_wa;
  assign u_we[UNIT_LS] = ls_we;
  assign u_we[UNIT_AR] = ar_we;
  assign u_wd[UNIT_LS] = ls_wd;
  assign u_wd[UNIT_AR] = ar_wd;

  // load/store unit owns bank bank_swap, arithmetic unit the other one
  assign own[UNIT_LS] = bank_swap;
  assign own[UNIT_AR] = ~bank_swap;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      rf_addr_dec #(
        .ADDR_W(ADDR_W), .PRIV_DEPTH(PRIV_DEPTH),
        .BANK_DEPTH(BANK_DEPTH), .IDX_W(IDX_W)
      ) u_dec (
        .addr(addr[u][p]), .kind(kind[u][p]), .bank(bsel[u][p]), .idx(idx[u][p])
      );
      assign legal[u][p] = (kind[u][p] == RK_PRIV) ||
                           (kind[u][p] == RK_SHR && bsel[u][p] == own[u]);
    end

    assign illeg[u] = !legal[u][0] || !legal[u][1] || (u_we[u] && !legal[u][2]);

    rf_bank #(.DATA_W(DATA_W), .DEPTH(PRIV_DEPTH), .IDX_W(PIDX_W)) u_priv (
      .clk(clk), .rst(rst),
      .we (u_we[u] && kind[u][2] == RK_PRIV),
      .wa (PIDX_W'(idx[u][2])), .wd(u_wd[u]),
      .ra0(PIDX_W'(idx[u][0])), .ra1(PIDX_W'(idx[u][1])),
      .rd0(prv_rd[u][0]), .rd1(prv_rd[u][1])
    );
  end

  // each shared bank has one port set, steered to its owner this cycle
  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic              owner;
    logic              b_we;
    logic [IDX_W-1:0]  b_wa, b_ra0, b_ra1;
    logic [DATA_W-1:0] b_wd;
    assign owner = bank_swap ^ 1'(b);   // 0: load/store, 1: arithmetic
    always_comb begin
      b_we  = 1'b0;
      b_wa  = idx[UNIT_LS][2];
      b_wd  = u_wd[UNIT_LS];
      b_ra0 = idx[UNIT_LS][0];
      b_ra1 = idx[UNIT_LS][1];
      if (owner == 1'b0) begin
        b_we = u_we[UNIT_LS] && kind[UNIT_LS][2] == RK_SHR && bsel[UNIT_LS][2] == 1'(b);
      end else begin
        b_we  = u_we[UNIT_AR] && kind[UNIT_AR][2] == RK_SHR && bsel[UNIT_AR][2] == 1'(b);
        b_wa  = idx[UNIT_AR][2];
        b_wd  = u_wd[UNIT_AR];
        b_ra0 = idx[UNIT_AR][0];
        b_ra1 = idx[UNIT_AR][1];
      end
    end
    rf_bank #(.DATA_W(DATA_W), .DEPTH(BANK_DEPTH), .IDX_W(BIDX_W)) u_shr (
      .clk(clk), .rst(rst), .we(b_we),
      .wa(BIDX_W'(b_wa)), .wd(b_wd),
      .ra0(BIDX_W'(b_ra0)), .ra1(BIDX_W'(b_ra1)),
      .rd0(bnk_rd[b][0]), .rd1(bnk_rd[b][1])
    );
  end

  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++) begin
      for (int p = 0; p < 2; p++) begin
        if (!legal[u][p])                rd[u][p] = '0;
        else if (kind[u][p] == RK_PRIV)  rd[u][p] = prv_rd[u][p];
        else                             rd[u][p] = bnk_rd[own[u]][p];
      end
    end
  end

  assign ls_rd0     = rd[UNIT_LS][0];
  assign ls_rd1     = rd[UNIT_LS][1];
  assign ar_rd0     = rd[UNIT_AR][0];
  assign ar_rd1     = rd[UNIT_AR][1];
  assign ls_illegal = illeg[UNIT_LS];
  assign ar_illegal = illeg[UNIT_AR];

  // R6
  bad_addr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ls_ra0 >= A_END) |-> (ls_illegal && ls_rd0 == '0));

  // R4
  unowned_read_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (bank_swap && ls_ra0 >= A_B0 && ls_ra0 < A_B1) |-> (ls_illegal && ls_rd0 == '0));

  // R9
  bank_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    (ls_ra0 == ar_ra0 && ls_ra0 >= A_B0 && ls_ra0 < A_END) |-> (ls_illegal || ar_illegal));
endmodule

// File: tb/sim_pingpong_cluster_rf.sv
`timescale 1ns/1ps
module sim_pingpong_cluster_rf;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bank_swap = 1'b0;
  logic [4:0] ls_ra0 = '0, ls_ra1 = '0, ls_wa = '0, ar_ra0 = '0, ar_ra1 = '0, ar_wa = '0;
  logic ls_we = 1'b0, ar_we = 1'b0;
  logic [31:0] ls_wd = '0, ar_wd = '0;
  logic [31:0] ls_rd0, ls_rd1, ar_rd0, ar_rd1;
  logic ls_illegal, ar_illegal;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  pingpong_cluster_rf u0 (
    .clk(clk), .rst(rst), .bank_swap(bank_swap),
    .ls_ra0(ls_ra0), .ls_ra1(ls_ra1), .ls_we(ls_we), .ls_wa(ls_wa), .ls_wd(ls_wd),
    .ls_rd0(ls_rd0), .ls_rd1(ls_rd1), .ls_illegal(ls_illegal),
    .ar_ra0(ar_ra0), .ar_ra1(ar_ra1), .ar_we(ar_we), .ar_wa(ar_wa), .ar_wd(ar_wd),
    .ar_rd0(ar_rd0), .ar_rd1(ar_rd1), .ar_illegal(ar_illegal)
  );

  typedef struct packed {
    logic        sw;
    logic        lwe; logic [4:0] lwa; logic [31:0] lwd; logic [4:0] lra;
    logic        awe; logic [4:0] awa; logic [31:0] awd; logic [4:0] ara;
    logic [31:0] elrd; logic elill; logic [31:0] eard; logic eaill;
  } vec_t;

  // R8 R3 R7 R4 R5 R2 R6 R10 R9, applied in order after reset
  localparam vec_t VEC [12] = '{
    '{1'b0, 1'b1,5'd9 ,32'h11111111,5'd9 , 1'b1,5'd17,32'h22222222,5'd17, 32'h11111111,1'b0,32'h22222222,1'b0},
    '{1'b0, 1'b0,5'd0 ,32'h0       ,5'd9 , 1'b0,5'd0 ,32'h0       ,5'd17, 32'h11111111,1'b0,32'h22222222,1'b0},
    '{1'b1, 1'b0,5'd0 ,32'h0       ,5'd17, 1'b0,5'd0 ,32'h0       ,5'd9 , 32'h22222222,1'b0,32'h11111111,1'b0},
    '{1'b1, 1'b0,5'd0 ,32'h0       ,5'd9 , 1'b0,5'd0 ,32'h0       ,5'd17, 32'h0       ,1'b1,32'h0       ,1'b1},
    '{1'b1, 1'b1,5'd10,32'hDEAD0000,5'd3 , 1'b1,5'd3 ,32'h33333333,5'd3 , 32'h0       ,1'b1,32'h33333333,1'b0},
    '{1'b0, 1'b0,5'd0 ,32'h0       ,5'd10, 1'b0,5'd0 ,32'h0       ,5'd3 , 32'h0       ,1'b0,32'h33333333,1'b0},
    '{1'b0, 1'b0,5'd0 ,32'h0       ,5'd3 , 1'b1,5'd25,32'h99999999,5'd25, 32'h0       ,1'b0,32'h0       ,1'b1},
    '{1'b0, 1'b1,5'd30,32'h55555555,5'd8 , 1'b0,5'd0 ,32'h0       ,5'd16, 32'h0       ,1'b1,32'h0       ,1'b0},
    '{1'b0, 1'b0,5'd0 ,32'h0       ,5'd9 , 1'b0,5'd0 ,32'h0       ,5'd9 , 32'h11111111,1'b0,32'h0       ,1'b1},
    '{1'b1, 1'b0,5'd0 ,32'h0       ,5'd17, 1'b0,5'd0 ,32'h0       ,5'd17, 32'h22222222,1'b0,32'h0       ,1'b1},
    '{1'b1, 1'b0,5'd0 ,32'h0       ,5'd31, 1'b1,5'd12,32'h66666666,5'd12, 32'h0       ,1'b1,32'h66666666,1'b0},
    '{1'b0, 1'b0,5'd0 ,32'h0       ,5'd12, 1'b0,5'd0 ,32'h0       ,5'd20, 32'h66666666,1'b0,32'h0       ,1'b0}
  };

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic idle();
    ls_we = 1'b0; ar_we = 1'b0;
    ls_ra0 = '0; ls_ra1 = '0; ls_wa = '0; ls_wd = '0;
    ar_ra0 = '0; ar_ra1 = '0; ar_wa = '0; ar_wd = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1: fresh state reads zero everywhere reachable
    #1;
    ls_ra0 = 5'd9; ls_ra1 = 5'd2; ar_ra0 = 5'd17; ar_ra1 = 5'd7;
    #1;
    check("R1", "ls D1 after reset", ls_rd0, 32'h0);
    check("R1", "ls A2 after reset", ls_rd1, 32'h0);
    check("R1", "ar D9 after reset", ar_rd0, 32'h0);
    check("R1", "ar AC7 after reset", ar_rd1, 32'h0);
    check("R1", "ls flag after reset", 32'(ls_illegal), 32'h0);

    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      idle();
      bank_swap = VEC[i].sw;
      ls_we = VEC[i].lwe; ls_wa = VEC[i].lwa; ls_wd = VEC[i].lwd; ls_ra0 = VEC[i].lra;
      ar_we = VEC[i].awe; ar_wa = VEC[i].awa; ar_wd = VEC[i].awd; ar_ra0 = VEC[i].ara;
      #1;
      check("R2-R10 vec", $sformatf("vec %0d ls_rd0", i), ls_rd0, VEC[i].elrd);
      check("R2-R10 vec", $sformatf("vec %0d ls_illegal", i), 32'(ls_illegal), 32'(VEC[i].elill));
      check("R2-R10 vec", $sformatf("vec %0d ar_rd0", i), ar_rd0, VEC[i].eard);
      check("R2-R10 vec", $sformatf("vec %0d ar_illegal", i), 32'(ar_illegal), 32'(VEC[i].eaill));
    end

    // R8 on read port 1
    @(negedge clk);
    idle(); bank_swap = 1'b0;
    ls_we = 1'b1; ls_wa = 5'd5; ls_wd = 32'h77777777; ls_ra1 = 5'd5;
    #1;
    check("R8", "ls port1 bypass", ls_rd1, 32'h77777777);
    // R4 on read port 1 of the arithmetic unit
    @(negedge clk);
    idle(); bank_swap = 1'b0; ar_ra1 = 5'd9;
    #1;
    check("R4", "ar port1 unowned read", ar_rd1, 32'h0);
    check("R4", "ar flag port1", 32'(ar_illegal), 32'h1);
    check("R10", "ls flag untouched", 32'(ls_illegal), 32'h0);
    ls_ra1 = 5'd5;
    #1;
    check("R7", "ls A5 after commit", ls_rd1, 32'h77777777);

    // R1: reset in mid-run clears written registers
    do_reset();
    bank_swap = 1'b0; ls_ra0 = 5'd9; ls_ra1 = 5'd5; ar_ra0 = 5'd3; ar_ra1 = 5'd17;
    #1;
    check("R1", "ls D1 cleared", ls_rd0, 32'h0);
    check("R1", "ls A5 cleared", ls_rd1, 32'h0);
    check("R1", "ar AC3 cleared", ar_rd0, 32'h0);
    check("R1", "ar D9 cleared", ar_rd1, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule